// File: doc/BRIEF.md
# Masked Interrupt Collector

This block gathers up to 32 interrupt lines into one request to the processor. Software reaches two words through a small register port: an enable word, with one bit per line, and a pending word, with one bit per line. Each line is configured when the block is built as edge-sensitive or level-sensitive. Edge lines set their pending bit on a rising edge, and the bit stays set until software acknowledges it. The request to the processor is raised when any pending bit is also enabled, and only while the processor's interrupt-enable input is high.

A build-time switch selects how acknowledges work. In the default convention, a 1 written to a pending bit clears it, and level lines simply follow their input. In the alternative convention, a 0 written to a pending bit clears it, and level lines are captured like edge lines. A combinational output gives the index of the lowest-numbered pending bit, so that a service loop can pick its next source without scanning. The block has no control state machine. Its only sequential state is three registers: the enable word, the pending word and the previous sample of the lines.

Top module: `intc_core`

## Requirements
- R1: After reset, the enable word and the pending word both read 0, `cpu_irq` is 0 and `low_valid` is 0.
- R2: A write with `reg_sel`=0 loads the whole enable word from `reg_wdata` at that clock edge. Reads are combinational: `reg_sel`=0 returns the enable word and `reg_sel`=1 returns the pending word.
- R3: An edge line is one whose bit in `LEVEL_MASK` is 0. Its pending bit is set at the first clock edge that samples the line high after a clock edge that sampled it low. It then stays set after the line falls, until it is acknowledged.
- R4: With `ACK_ZERO`=0, a write with `reg_sel`=1 clears every latched pending bit whose `reg_wdata` bit is 1. Bits written with 0 are left unchanged.
- R5: With `ACK_ZERO`=1, a write with `reg_sel`=1 clears every pending bit whose `reg_wdata` bit is 0. Bits written with 1 are left unchanged.
- R6: With `ACK_ZERO`=0, the pending bit of a level line (its `LEVEL_MASK` bit is 1) equals the line value sampled at the previous clock edge. Pending-word writes have no effect on such a bit.
- R7: With `ACK_ZERO`=1, the pending bit of a level line is set on any clock edge that samples the line high. It stays set after the line falls, until it is acknowledged.
- R8: When a set event and a clearing write reach the same latched bit at the same clock edge, the bit ends up set.
- R9: `cpu_irq` is 1 exactly when `cpu_ie` is 1 and at least one bit is set in both the pending word and the enable word.
- R10: `low_valid` is 1 when any pending bit is set. `low_idx` then gives the lowest-numbered set pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 is the enable word, 1 is the pending word |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_in | input | 32 | Interrupt lines |
| cpu_ie | input | 1 | Processor interrupt-enable flag |
| cpu_irq | output | 1 | Interrupt request to the processor |
| low_idx | output | 5 | Index of the lowest pending bit |
| low_valid | output | 1 | Some pending bit is set |

## Verification
The assertions assume that the interrupt lines and the register port change only between clock edges and are steady at each rising edge. They also assume that the enable word is written only as a full word, as the result of a software read-modify-write. The stimulus changes every input one time unit after a rising edge and samples the outputs at that point. Same-edge collisions, such as a rising edge that arrives together with a clearing write, are therefore built deliberately inside one cycle, never by a race.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register select encoding of the access port
    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } intc_sel_e;

    parameter int unsigned INTC_LINES_DEF = 32;

endpackage

// File: rtl/intc_enable.sv
module intc_enable #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data;
        end
    end

    // R2: a write loads the whole word
    assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data)));

endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int unsigned N          = 32,
    parameter logic [N-1:0] LEVEL_MASK = '0,
    parameter bit          ACK_ZERO   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] pend_q
);

    logic [N-1:0] prev_q;
    logic [N-1:0] pend_d;
    logic [N-1:0] hit;
    logic [N-1:0] clr;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LEVEL_MASK[i] && !ACK_ZERO) begin : g_follow
            // level line, standard convention: tracks the line
            assign hit[i]    = lines[i];
            assign clr[i]    = 1'b0;
            assign pend_d[i] = lines[i];

            assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pend_q[i] == $past(lines[i])));
        end else begin : g_latch
            if (LEVEL_MASK[i]) begin : g_lvl
                assign hit[i] = lines[i];
            end else begin : g_edge
                assign hit[i] = lines[i] & ~prev_q[i];
            end
            if (ACK_ZERO) begin : g_ack0
                assign clr[i] = wr_en & ~wr_data[i];
            end else begin : g_ack1
                assign clr[i] = wr_en & wr_data[i];
            end
            // a new event outranks a clearing write
            assign pend_d[i] = hit[i] | (pend_q[i] & ~clr[i]);

            assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> pend_q[i]);
            assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[i] && !clr[i]) |=> pend_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lines;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
    parameter int unsigned N = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                idx   = IW'(k);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int unsigned N_LINES    = INTC_LINES_DEF,
    parameter logic [N_LINES-1:0] LEVEL_MASK = N_LINES'(32'h0000_FF00),
    parameter bit          ACK_ZERO   = 1'b0,
    localparam int unsigned IW        = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               cpu_ie,
    output logic               cpu_irq,
    output logic [IW-1:0]      low_idx,
    output logic               low_valid
);

    intc_sel_e          sel;
    logic [N_LINES-1:0] en_q;
    logic [N_LINES-1:0] pend_q;
    logic               en_wr;
    logic               pend_wr;

    assign sel     = intc_sel_e'(reg_sel);
    assign en_wr   = reg_we && (sel == SEL_ENABLE);
    assign pend_wr = reg_we && (sel == SEL_PENDING);

    intc_enable #(.N(N_LINES)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_wr),
        .wr_data (reg_wdata),
        .en_q    (en_q)
    );

    intc_pending #(
        .N          (N_LINES),
        .LEVEL_MASK (LEVEL_MASK),
        .ACK_ZERO   (ACK_ZERO)
    ) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_in),
        .wr_en   (pend_wr),
        .wr_data (reg_wdata),
        .pend_q  (pend_q)
    );

    intc_lowest #(.N(N_LINES)) u_lowest (
        .vec   (pend_q),
        .idx   (low_idx),
        .valid (low_valid)
    );

    always_comb begin
        unique case (sel)
            SEL_ENABLE:  reg_rdata = en_q;
            SEL_PENDING: reg_rdata = pend_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign cpu_irq = cpu_ie & (|(pend_q & en_q));

    // bits below the reported index, used by the R10 check
    logic [N_LINES-1:0] below;
    assign below = ({{(N_LINES-1){1'b0}}, 1'b1} << low_idx) - 1'b1;

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> cpu_ie);
    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ie && low_valid && en_q[low_idx]) |-> cpu_irq);
    assert_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        low_valid |-> (pend_q[low_idx] && ((pend_q & below) == '0)));
    assert_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !low_valid |-> (pend_q == '0));

endmodule

// File: tb/test_intc_core.sv
module test_intc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;
    logic        we_s = 1'b0;
    logic        we_z = 1'b0;
    logic [31:0] lines = '0;
    logic        ie = 1'b0;
    logic [31:0] rd_s, rd_z;
    logic        irq_s, irq_z, val_s, val_z;
    logic [4:0]  idx_s, idx_z;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    intc_core i_intc_core (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we_s), .reg_wdata(wdata),
        .reg_rdata(rd_s), .irq_in(lines), .cpu_ie(ie), .cpu_irq(irq_s),
        .low_idx(idx_s), .low_valid(val_s)
    );

    intc_core #(.ACK_ZERO(1'b1)) i_intc_core_zero (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we_z), .reg_wdata(wdata),
        .reg_rdata(rd_z), .irq_in(lines), .cpu_ie(ie), .cpu_irq(irq_z),
        .low_idx(idx_z), .low_valid(val_z)
    );

    // {lines, ie, expected pending (standard), expected request (standard)}
    localparam logic [65:0] VECS [6] = '{
        {32'h0000_0001, 1'b1, 32'h0000_0001, 1'b1},
        {32'h0000_0000, 1'b1, 32'h0000_0001, 1'b1},
        {32'h0000_0100, 1'b0, 32'h0000_0101, 1'b0},
        {32'h0000_0000, 1'b1, 32'h0000_0001, 1'b1},
        {32'h0001_0000, 1'b1, 32'h0001_0001, 1'b1},
        {32'h0001_0000, 1'b0, 32'h0001_0001, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr_s(logic s, logic [31:0] d);
        sel = s; wdata = d; we_s = 1'b1;
        tick();
        we_s = 1'b0;
    endtask

    task automatic wr_z(logic s, logic [31:0] d);
        sel = s; wdata = d; we_z = 1'b1;
        tick();
        we_z = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        sel = 1'b0; #1;
        chk("R1 enable", rd_s, 32'h0);
        sel = 1'b1; #1;
        chk("R1 pending", rd_s, 32'h0);
        chk("R1 irq/valid", {30'h0, irq_s, val_s}, 32'h0);
        chk("R1 alt pending", rd_z, 32'h0);
        rst_n = 1'b1;
        tick();

        // R2 enable word load and read-back
        wr_s(1'b0, 32'h0000_0F03);
        sel = 1'b0; #1;
        chk("R2 enable readback", rd_s, 32'h0000_0F03);
        chk("R2 alt enable untouched", rd_z, 32'h0);

        // table: R3 edge latch, R6 level follow, R9 request gating
        sel = 1'b1;
        for (int n = 0; n < 6; n++) begin
            lines = VECS[n][65:34];
            ie    = VECS[n][33];
            tick();
            chk($sformatf("R3/R6 pending vec%0d", n), rd_s, VECS[n][32:1]);
            chk($sformatf("R9 irq vec%0d", n), {31'h0, irq_s}, {31'h0, VECS[n][0]});
        end
        // R7: alternative convention held level line 8 after it fell
        chk("R7 alt level latched", rd_z, 32'h0001_0101);

        // R4: write 1 clears bit 16; line still high, no new edge
        wr_s(1'b1, 32'h0001_0000);
        chk("R4 ack by one", rd_s, 32'h0000_0001);

        // R6: level bit ignores the write, follows the line
        lines = 32'h0000_0100;
        wr_s(1'b1, 32'h0000_0100);
        chk("R6 write ignored on level", rd_s, 32'h0000_0101);

        // R8: rising edge on line 1 together with a clear of bit 1
        lines = 32'h0000_0102;
        wr_s(1'b1, 32'h0000_0002);
        chk("R8 event wins", rd_s, 32'h0000_0103);
        chk("R10 lowest index 0", {26'h0, val_s, idx_s}, {26'h0, 1'b1, 5'd0});

        // clear bits 0 and 1, level line 8 remains
        lines = 32'h0000_0100;
        ie = 1'b1;
        wr_s(1'b1, 32'h0000_0003);
        chk("R4 multi-bit ack", rd_s, 32'h0000_0100);
        chk("R10 lowest index 8", {26'h0, val_s, idx_s}, {26'h0, 1'b1, 5'd8});
        chk("R9 irq from level", {31'h0, irq_s}, 32'h1);

        lines = 32'h0;
        tick();
        chk("R6 level drop", rd_s, 32'h0);
        chk("R10 none pending", {31'h0, val_s}, 32'h0);
        chk("R9 no irq", {31'h0, irq_s}, 32'h0);

        // alternative convention
        chk("R7 alt state", rd_z, 32'h0001_0103);
        wr_z(1'b1, 32'hFFFF_FEFF);
        chk("R5 ack by zero", rd_z, 32'h0001_0003);
        wr_z(1'b1, 32'h0000_0000);
        chk("R5 clear all", rd_z, 32'h0);
        lines = 32'h0000_0004;
        wr_z(1'b1, 32'h0000_0000);
        chk("R8 alt event wins", rd_z, 32'h0000_0004);
        chk("R10 alt lowest 2", {26'h0, val_z, idx_z}, {26'h0, 1'b1, 5'd2});
        chk("R9 alt disabled line", {31'h0, irq_z}, 32'h0);
        chk("R3 std edge bit2", rd_s, 32'h0000_0004);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule